// File: doc/BRIEF.md
# Palette RAM access port

This block holds a palette of 512 colour entries, each 9 bits wide, and gives a processor byte-wide access to it through eight register offsets. One offset carries a video mode control byte. Two carry a 9-bit entry pointer, split into a low byte and a one-bit high part. Two carry the entry contents, also split into a low byte and a one-bit high part. The pointer steps forward on every high-part data access. A program sets the pointer once and then streams pairs of bytes to fill the palette, or to dump it.

A second port serves the pixel side. A pixel index enters under a valid/ready handshake, and its colour leaves one cycle later under a second valid/ready handshake. Some indices do not have a colour of their own. Any index whose low four bits are zero resolves to one of two shared backdrop entries. The choice between them follows the top index bit. The control byte is decoded into a dot-clock mode, a frame-length select and a monochrome flag, and these are presented as plain outputs.

The backpressure rule on the pixel side is as follows. `pix_ready` is high when the output stage is empty or when `col_ready` is high. While `col_valid` is high and `col_ready` is low, both the colour and `col_valid` hold. An index offered during that time is not taken.

Top module: `pal_port`

## Requirements
- R1: After reset the pointer and every palette entry are zero, `dot_mode`, `tall_frame` and `mono` are 0, and `col_valid` is 0.
- R2: A write to offset 4 (data low) replaces bits 7:0 of the pointed-to entry and leaves the pointer unchanged.
- R3: A write to offset 5 (data high) replaces bit 8 of the pointed-to entry with `wdata[0]` and then advances the pointer by one.
- R4: A read of offset 4 returns bits 7:0 of the pointed-to entry and leaves the pointer unchanged. A read of offset 5 returns the entry's bit 8 in bit 0, with bits 7:1 set to 1, and then advances the pointer. Read data appears on `rdata` in the cycle after the read strobe.
- R5: A read of offsets 0, 1, 2, 3, 6 or 7 returns 0xFF and leaves the pointer unchanged.
- R6: A write to offset 2 sets pointer bits 7:0 and keeps bit 8. A write to offset 3 sets pointer bit 8 from `wdata[0]` and keeps bits 7:0.
- R7: The pointer is 9 bits wide and steps from 511 to 0.
- R8: A write to offset 0 sets the mode outputs. `dot_mode` is 2 when `wdata[1]` is 1, and otherwise equals `wdata[0]`. `tall_frame` is `wdata[2]`, which selects 263 lines per frame. `mono` is `wdata[7]`.
- R9: The colour returned for an index whose bits 3:0 are zero is entry 0x000 when index bit 8 is 0, and entry 0x100 when it is 1. Every other index returns its own entry.
- R10: An accepted index produces `col_valid` with its colour on the next cycle. While `col_valid` is high and `col_ready` is low, `col_data` and `col_valid` hold and `pix_ready` is low.
- R11: A strobe without `cs` changes no entry, pointer or mode output. When `rd` and `wr` are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register port select |
| rd | input | 1 | Single-cycle read strobe |
| wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 3 | Register offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after `rd` |
| dot_mode | output | 2 | Dot-clock mode 0, 1 or 2 |
| tall_frame | output | 1 | 263-line frame select |
| mono | output | 1 | Monochrome flag |
| pix_valid | input | 1 | Pixel index offered |
| pix_ready | output | 1 | Pixel index can be taken |
| pix_index | input | 9 | Pixel colour index |
| col_valid | output | 1 | Colour output valid |
| col_ready | input | 1 | Colour consumer ready |
| col_data | output | 9 | Resolved 9-bit colour |

## Verification
The bench builds the block with its default parameters: a 9-bit pointer and 9-bit entries. With these values the full 512-entry space and both backdrop entries are in range. The pointer is placed at 0x1FE by direct register writes, so the step from 511 to 0 is reached in a few accesses rather than after a full sweep. Both halves of the split pointer and data registers are exercised at their only meaningful high bit.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OFF_CTRL    = 3'd0,
    OFF_PTR_LO  = 3'd2,
    OFF_PTR_HI  = 3'd3,
    OFF_DATA_LO = 3'd4,
    OFF_DATA_HI = 3'd5
  } reg_off_e;
endpackage

// File: rtl/pal_mem.sv
module pal_mem #(
  parameter int ADDR_W  = 9,
  parameter int COLOR_W = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               acc_addr,
  input  logic                            we_lo,
  input  logic                            we_hi,
  input  logic [pal_pkg::BYTE_W-1:0]      wr_byte,
  input  logic [COLOR_W-pal_pkg::BYTE_W-1:0] wr_top,
  output logic [COLOR_W-1:0]              acc_q,
  input  logic [ADDR_W-1:0]               lk_addr,
  output logic [COLOR_W-1:0]              lk_q
);
  import pal_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [COLOR_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = (acc_addr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent[g] <= '0;
      end else begin
        if (we_lo && hit) ent[g][BYTE_W-1:0] <= wr_byte;
        if (we_hi && hit) ent[g][COLOR_W-1:BYTE_W] <= wr_top;
      end
    end
  end

  assign acc_q = ent[acc_addr];
  assign lk_q  = ent[lk_addr];
endmodule

// File: rtl/pal_regs.sv
module pal_regs #(
  parameter int ADDR_W  = 9,
  parameter int COLOR_W = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs,
  input  logic                            rd,
  input  logic                            wr,
  input  logic [2:0]                      reg_addr,
  input  logic [pal_pkg::BYTE_W-1:0]      wdata,
  output logic [pal_pkg::BYTE_W-1:0]      rdata,
  output logic [ADDR_W-1:0]               acc_addr,
  output logic                            we_lo,
  output logic                            we_hi,
  output logic [pal_pkg::BYTE_W-1:0]      wr_byte,
  output logic [COLOR_W-pal_pkg::BYTE_W-1:0] wr_top,
  input  logic [COLOR_W-1:0]              acc_q,
  output logic [1:0]                      dot_mode,
  output logic                            tall_frame,
  output logic                            mono
);
  import pal_pkg::*;
  localparam int PHI_W = ADDR_W - BYTE_W;
  localparam int CHI_W = COLOR_W - BYTE_W;
  localparam int PAD_W = BYTE_W - CHI_W;

  logic wr_go, rd_go;
  logic [ADDR_W-1:0] ptr_q;

  assign wr_go    = cs && wr;
  assign rd_go    = cs && rd && !wr;
  assign we_lo    = wr_go && (reg_addr == OFF_DATA_LO);
  assign we_hi    = wr_go && (reg_addr == OFF_DATA_HI);
  assign wr_byte  = wdata;
  assign wr_top   = wdata[CHI_W-1:0];
  assign acc_addr = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      rdata      <= '1;
      dot_mode   <= 2'd0;
      tall_frame <= 1'b0;
      mono       <= 1'b0;
    end else if (wr_go) begin
      unique case (reg_addr)
        OFF_CTRL: begin
          dot_mode   <= wdata[1] ? 2'd2 : {1'b0, wdata[0]};
          tall_frame <= wdata[2];
          mono       <= wdata[7];
        end
        OFF_PTR_LO:  ptr_q[BYTE_W-1:0] <= wdata;
        OFF_PTR_HI:  ptr_q[ADDR_W-1:BYTE_W] <= wdata[PHI_W-1:0];
        OFF_DATA_HI: ptr_q <= ptr_q + 1'b1;
        default: ;
      endcase
    end else if (rd_go) begin
      unique case (reg_addr)
        OFF_DATA_LO: rdata <= acc_q[BYTE_W-1:0];
        OFF_DATA_HI: begin
          rdata <= {{PAD_W{1'b1}}, acc_q[COLOR_W-1:BYTE_W]};
          ptr_q <= ptr_q + 1'b1;
        end
        default: rdata <= '1;
      endcase
    end
  end

  assert_lo_keeps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && reg_addr == OFF_DATA_LO) |=> $stable(ptr_q));
  assert_hi_steps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && reg_addr == OFF_DATA_HI) |=> (ptr_q == $past(ptr_q) + 1'b1));
  assert_hi_read_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && reg_addr == OFF_DATA_HI) |=> (rdata[BYTE_W-1:CHI_W] == '1));
  assert_other_read_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && reg_addr != OFF_DATA_LO && reg_addr != OFF_DATA_HI)
      |=> (rdata == '1) && $stable(ptr_q));
  assert_mode_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && reg_addr == OFF_CTRL && wdata[1]) |=> (dot_mode == 2'd2));
  assert_no_cs_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs) |=> $stable(ptr_q) && $stable(dot_mode));
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup #(
  parameter int ADDR_W  = 9,
  parameter int COLOR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [ADDR_W-1:0]  pix_index,
  output logic [ADDR_W-1:0]  lk_addr,
  input  logic [COLOR_W-1:0] lk_q,
  output logic               col_valid,
  input  logic               col_ready,
  output logic [COLOR_W-1:0] col_data
);
  import pal_pkg::*;

  logic fire;

  assign pix_ready = !col_valid || col_ready;
  assign fire      = pix_valid && pix_ready;
  assign lk_addr   = (pix_index[NIB_W-1:0] == '0)
                   ? {pix_index[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}
                   : pix_index;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_data  <= '0;
    end else if (fire) begin
      col_valid <= 1'b1;
      col_data  <= lk_q;
    end else if (col_ready) begin
      col_valid <= 1'b0;
    end
  end

  assert_accept_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> col_valid);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |=> col_valid && $stable(col_data));
endmodule

// File: rtl/pal_port.sv
module pal_port #(
  parameter int ADDR_W  = 9,
  parameter int COLOR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               rd,
  input  logic               wr,
  input  logic [2:0]         reg_addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [1:0]         dot_mode,
  output logic               tall_frame,
  output logic               mono,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [ADDR_W-1:0]  pix_index,
  output logic               col_valid,
  input  logic               col_ready,
  output logic [COLOR_W-1:0] col_data
);
  import pal_pkg::*;
  localparam int CHI_W = COLOR_W - BYTE_W;

  logic [ADDR_W-1:0]  acc_addr, lk_addr;
  logic               we_lo, we_hi;
  logic [BYTE_W-1:0]  wr_byte;
  logic [CHI_W-1:0]   wr_top;
  logic [COLOR_W-1:0] acc_q, lk_q;

  pal_regs #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata),
    .acc_addr(acc_addr), .we_lo(we_lo), .we_hi(we_hi),
    .wr_byte(wr_byte), .wr_top(wr_top), .acc_q(acc_q),
    .dot_mode(dot_mode), .tall_frame(tall_frame), .mono(mono)
  );

  pal_mem #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr),
    .we_lo(we_lo), .we_hi(we_hi), .wr_byte(wr_byte), .wr_top(wr_top),
    .acc_q(acc_q), .lk_addr(lk_addr), .lk_q(lk_q)
  );

  pal_lookup #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_index(pix_index), .lk_addr(lk_addr), .lk_q(lk_q),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data)
  );
endmodule

// File: tb/pal_port_bench.sv
module pal_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] dot_mode;
  logic       tall_frame, mono;
  logic       pix_valid = 1'b0, pix_ready;
  logic [8:0] pix_index = '0;
  logic       col_valid, col_ready = 1'b1;
  logic [8:0] col_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [8:0] m_pal [512];
  logic [8:0] m_ptr = '0;

  always #5 clk = ~clk;

  pal_port u_pal_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata),
    .dot_mode(dot_mode), .tall_frame(tall_frame), .mono(mono),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_index(pix_index),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] o, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; rd = 1'b0; reg_addr = o; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (sel) begin
      case (o)
        3'd2: m_ptr[7:0] = d;
        3'd3: m_ptr[8] = d[0];
        3'd4: m_pal[m_ptr][7:0] = d;
        3'd5: begin m_pal[m_ptr][8] = d[0]; m_ptr = m_ptr + 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic rd_chk(input logic [2:0] o, input string req);
    logic [7:0] exp;
    case (o)
      3'd4: exp = m_pal[m_ptr][7:0];
      3'd5: exp = {7'h7F, m_pal[m_ptr][8]};
      default: exp = 8'hFF;
    endcase
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b0; reg_addr = o;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    if (o == 3'd5) m_ptr = m_ptr + 1'b1;
    chk(req, {8'h0, rdata}, {8'h0, exp});
  endtask

  task automatic set_ptr(input logic [8:0] p);
    wr_reg(3'd2, p[7:0]);
    wr_reg(3'd3, {7'h0, p[8]});
  endtask

  task automatic set_entry(input logic [8:0] idx, input logic [8:0] v);
    set_ptr(idx);
    wr_reg(3'd4, v[7:0]);
    wr_reg(3'd5, {7'h0, v[8]});
  endtask

  function automatic logic [8:0] lk_exp(input logic [8:0] idx);
    return (idx[3:0] == 4'h0) ? m_pal[{idx[8], 8'h00}] : m_pal[idx];
  endfunction

  task automatic t_reset;
    chk("R1 dot_mode", {14'h0, dot_mode}, 16'h0);
    chk("R1 tall_frame", {15'h0, tall_frame}, 16'h0);
    chk("R1 mono", {15'h0, mono}, 16'h0);
    chk("R1 col_valid", {15'h0, col_valid}, 16'h0);
    rd_chk(3'd4, "R1 entry 0 low");
    rd_chk(3'd5, "R1 entry 0 high");
    rd_chk(3'd4, "R1 entry 1 low after step");
  endtask

  task automatic t_ctrl;
    wr_reg(3'd0, 8'h01);
    chk("R8 mode 1", {14'h0, dot_mode}, 16'd1);
    wr_reg(3'd0, 8'h03);
    chk("R8 mode forced by bit1", {14'h0, dot_mode}, 16'd2);
    wr_reg(3'd0, 8'h84);
    chk("R8 mode 0", {14'h0, dot_mode}, 16'd0);
    chk("R8 tall", {15'h0, tall_frame}, 16'd1);
    chk("R8 mono", {15'h0, mono}, 16'd1);
    wr_reg(3'd0, 8'h02);
    chk("R8 mode 2", {14'h0, dot_mode}, 16'd2);
    chk("R8 tall cleared", {15'h0, tall_frame}, 16'd0);
  endtask

  task automatic t_data_order;
    set_ptr(9'h010);
    wr_reg(3'd4, 8'hA5);
    wr_reg(3'd4, 8'h5A);
    wr_reg(3'd5, 8'h01);
    chk("R3 model step", {7'h0, m_ptr}, 16'h011);
    set_ptr(9'h010);
    rd_chk(3'd4, "R2 low replaced, R4 low read");
    rd_chk(3'd4, "R4 low read no step");
    rd_chk(3'd5, "R4 high read padded");
    rd_chk(3'd4, "R3 R4 pointer stepped to next entry");
  endtask

  task automatic t_ptr_fields;
    set_ptr(9'h134);
    wr_reg(3'd4, 8'h11);
    wr_reg(3'd5, 8'h00);
    wr_reg(3'd2, 8'h34);
    wr_reg(3'd3, 8'hFE);
    rd_chk(3'd4, "R6 high write uses bit0 only");
    wr_reg(3'd3, 8'h03);
    rd_chk(3'd4, "R6 high write keeps low byte");
    wr_reg(3'd2, 8'h35);
    rd_chk(3'd5, "R6 low write keeps bit8");
  endtask

  task automatic t_wrap;
    set_ptr(9'h1FE);
    wr_reg(3'd4, 8'h21); wr_reg(3'd5, 8'h01);
    wr_reg(3'd4, 8'h42); wr_reg(3'd5, 8'h00);
    chk("R7 model wrapped", {7'h0, m_ptr}, 16'h000);
    wr_reg(3'd4, 8'h33); wr_reg(3'd5, 8'h01);
    set_ptr(9'h1FF);
    rd_chk(3'd4, "R7 entry 511 low");
    rd_chk(3'd5, "R7 entry 511 high");
    rd_chk(3'd4, "R7 read wrapped to entry 0");
    rd_chk(3'd5, "R7 entry 0 high");
  endtask

  task automatic t_other;
    set_ptr(9'h010);
    for (int o = 0; o < 8; o++) begin
      if (o != 4 && o != 5) rd_chk(3'(o), "R5 other offset reads FF");
    end
    rd_chk(3'd4, "R5 pointer unchanged by other reads");
  endtask

  task automatic t_no_cs;
    set_ptr(9'h010);
    wr_reg(3'd4, 8'hEE, 1'b0);
    wr_reg(3'd5, 8'hFF, 1'b0);
    wr_reg(3'd0, 8'h01, 1'b0);
    chk("R11 mode unchanged", {14'h0, dot_mode}, 16'd2);
    rd_chk(3'd4, "R11 entry and pointer unchanged");
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b1; reg_addr = 3'd4; wdata = 8'h77;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    m_pal[m_ptr][7:0] = 8'h77;
    rd_chk(3'd4, "R11 write wins over read");
  endtask

  task automatic lk(input logic [8:0] idx, input string req);
    col_ready = 1'b1;
    @(negedge clk);
    pix_valid = 1'b1; pix_index = idx;
    @(negedge clk);
    pix_valid = 1'b0;
    chk(req, {7'h0, col_data}, {7'h0, lk_exp(idx)});
    chk("R10 col_valid after accept", {15'h0, col_valid}, 16'd1);
  endtask

  task automatic t_lookup;
    set_entry(9'h000, 9'h012);
    set_entry(9'h100, 9'h1AB);
    set_entry(9'h020, 9'h0CC);
    set_entry(9'h130, 9'h055);
    set_entry(9'h121, 9'h077);
    set_entry(9'h0F1, 9'h1E1);
    lk(9'h020, "R9 low-half redirect to 0x000");
    lk(9'h130, "R9 high-half redirect to 0x100");
    lk(9'h121, "R9 own entry high half");
    lk(9'h0F1, "R9 own entry low half");
    lk(9'h000, "R9 backdrop 0x000");
    lk(9'h100, "R9 backdrop 0x100");
  endtask

  task automatic t_stall;
    @(negedge clk);
    col_ready = 1'b0; pix_valid = 1'b1; pix_index = 9'h121;
    @(negedge clk);
    chk("R10 first taken", {7'h0, col_data}, 16'h077);
    chk("R10 ready low when stalled", {15'h0, pix_ready}, 16'd0);
    pix_index = 9'h0F1;
    @(negedge clk);
    chk("R10 data held in stall", {7'h0, col_data}, 16'h077);
    chk("R10 valid held in stall", {15'h0, col_valid}, 16'd1);
    col_ready = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R10 second taken after release", {7'h0, col_data}, 16'h1E1);
    @(negedge clk);
    chk("R10 valid drops when drained", {15'h0, col_valid}, 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) m_pal[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl;
    t_data_order;
    t_ptr_fields;
    t_wrap;
    t_other;
    t_no_cs;
    t_lookup;
    t_stall;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule